// File: doc/BRIEF.md
# System Management Mode Sequencer

This block follows a processor model into and out of its system management mode. The mode can start in two ways. An external agent can pull a shared, active-low request pin low, synchronous to the clock. The instruction decoder can also raise a software request strobe. Once a request is recognised, the block waits for the operation in flight to finish. It then takes over the pin and holds it low. It runs the state save, handler and state restore phases by handshaking with a separate save/restore bus sequencer and with the handler code.

For the whole time the mode is active, the block blocks maskable and non-maskable interrupts and disables pipelining. When the last restore read has finished, it drives the pin high for exactly two cycles and then releases it to high impedance. The pin appears at the ports as a sampled input level, a drive enable and a drive value. The pad or the integrating logic resolves these onto the shared wire.

Top module: `smm_mode_ctrl`

## Requirements
- R1: While reset is held and just after it, `mode_active_o`, `pin_oe_o`, `save_req_o`, `restore_req_o` and `handler_go_o` are all 0.
- R2: A low level on `smi_pin_i`, captured by the clock edge while the block is idle, makes `mode_active_o` rise at the next edge. `pin_oe_o` stays 0 in that first active cycle.
- R3: The block starts driving the pin low (`pin_oe_o`=1, `pin_val_o`=0) and raises `save_req_o` only at the edge after a cycle in which `op_busy_i` is 0. If `op_busy_i` stays 1, the block keeps waiting.
- R4: The phases follow a fixed order. `save_req_o` stays high until `save_done_i`. The handler phase then runs until `handler_exit_i`. `restore_req_o` then stays high until `restore_done_i`. The pin is driven low through all three phases.
- R5: When the handler phase begins, `handler_go_o` is 1 for exactly one cycle and `fetch_addr_o` shows 24'hFFFFF0 in that cycle. In every other cycle `fetch_addr_o` is 0.
- R6: After `restore_done_i`, the pin is driven high (`pin_oe_o`=1, `pin_val_o`=1) for exactly two cycles. After that `pin_oe_o` is 0 and `mode_active_o` is 0.
- R7: `intr_mask_o` and `pipe_off_o` are 1 exactly while `mode_active_o` is 1.
- R8: A cycle with `sw_trigger_i`=1 and `sw_enable_i`=1 (bit 12 of the debug control register) starts the same sequence as a pin request. With `sw_enable_i`=0 the trigger has no effect.
- R9: A software trigger or pin request that arrives while the mode is active is ignored. The sequence in progress is not altered, and the mode does not start again after the release.
- R10: A low pulse on `smi_pin_i` that begins and ends between two rising clock edges is never recognised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smi_pin_i | input | 1 | Level seen on the shared request pin |
| sw_trigger_i | input | 1 | Decoder strobe: trigger opcode executed |
| sw_enable_i | input | 1 | Software request enable bit of the debug control register |
| op_busy_i | input | 1 | A bus cycle or instruction is still in progress |
| save_done_i | input | 1 | Save sequencer finished the state save |
| handler_exit_i | input | 1 | Handler executed its resume sequence |
| restore_done_i | input | 1 | Final saved-state read of the restore completed |
| pin_oe_o | output | 1 | Drive enable for the request pin |
| pin_val_o | output | 1 | Level driven on the request pin when enabled |
| mode_active_o | output | 1 | Management mode in progress |
| intr_mask_o | output | 1 | Blocks maskable and non-maskable interrupts |
| pipe_off_o | output | 1 | Disables pipelining |
| save_req_o | output | 1 | Request to the sequencer to save state |
| restore_req_o | output | 1 | Request to the sequencer to restore state |
| handler_go_o | output | 1 | One-cycle pulse as the handler phase begins |
| fetch_addr_o | output | 24 | Handler fetch start address, valid with handler_go_o |

## Verification
The properties assume that the completion strobes arrive only while their own phase is pending. They also assume that the external agent does not pull the pin low during the two-cycle high preamble. The stimulus pulses `save_done_i`, `handler_exit_i` and `restore_done_i` only in the matching phase. It lets go of the external pin once `save_req_o` is seen. Late requests are injected only in the handler phase, where the block already drives the pin low.

// File: rtl/smm_pkg.sv
package smm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_WAIT    = 3'd1,
    ST_SAVE    = 3'd2,
    ST_HANDLER = 3'd3,
    ST_RESTORE = 3'd4,
    ST_PREHI   = 3'd5
  } smm_state_e;

  localparam int PREAMBLE_CYCLES = 2;
  localparam int PRE_CNT_W       = $clog2(PREAMBLE_CYCLES + 1);
endpackage

// File: rtl/smm_rst_sync.sv
module smm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/smm_pin_sample.sv
module smm_pin_sample (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic pin_low_q
);
  logic pin_q;

  // Registered level only: a sub-cycle glitch is never seen
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b1;
    else        pin_q <= pin_i;
  end

  assign pin_low_q = ~pin_q;
endmodule

// File: rtl/smm_seq_fsm.sv
module smm_seq_fsm
  import smm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hw_req,
  input  logic       sw_req,
  input  logic       op_busy,
  input  logic       save_done,
  input  logic       handler_exit,
  input  logic       restore_done,
  output smm_state_e state,
  output logic       handler_entry
);
  smm_state_e state_q, state_d;
  logic [PRE_CNT_W-1:0] cnt_q, cnt_d;
  logic cnt_en;
  logic entry_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (state_q)
      ST_IDLE:    if (hw_req || sw_req) state_d = ST_WAIT;
      ST_WAIT:    if (!op_busy)         state_d = ST_SAVE;
      ST_SAVE:    if (save_done)        state_d = ST_HANDLER;
      ST_HANDLER: if (handler_exit)     state_d = ST_RESTORE;
      ST_RESTORE: if (restore_done) begin
        state_d = ST_PREHI;
        cnt_d   = '0;
        cnt_en  = 1'b1;
      end
      ST_PREHI: begin
        cnt_en = 1'b1;
        if (cnt_q == PRE_CNT_W'(PREAMBLE_CYCLES - 1)) state_d = ST_IDLE;
        else cnt_d = cnt_q + 1'b1;
      end
      default:    state_d = ST_IDLE;
    endcase
  end

  assign entry_d = (state_d == ST_HANDLER) && (state_q != ST_HANDLER);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      entry_q <= 1'b0;
    end else begin
      state_q <= state_d;
      entry_q <= entry_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  logic entry_q;
  assign state         = state_q;
  assign handler_entry = entry_q;
endmodule

// File: rtl/smm_out_decode.sv
module smm_out_decode
  import smm_pkg::*;
#(
  parameter int              ADDR_W      = 24,
  parameter logic [ADDR_W-1:0] HANDLER_VEC = 24'hFFFFF0
) (
  input  smm_state_e        state,
  input  logic              handler_entry,
  output logic              pin_oe,
  output logic              pin_val,
  output logic              active,
  output logic              save_req,
  output logic              restore_req,
  output logic              handler_go,
  output logic [ADDR_W-1:0] fetch_addr
);
  always_comb begin
    active      = (state != ST_IDLE);
    pin_oe      = (state == ST_SAVE) || (state == ST_HANDLER) ||
                  (state == ST_RESTORE) || (state == ST_PREHI);
    pin_val     = (state == ST_PREHI);
    save_req    = (state == ST_SAVE);
    restore_req = (state == ST_RESTORE);
    handler_go  = handler_entry && (state == ST_HANDLER);
    fetch_addr  = handler_go ? HANDLER_VEC : '0;
  end
endmodule

// File: rtl/smm_mode_ctrl.sv
module smm_mode_ctrl
  import smm_pkg::*;
#(
  parameter int                ADDR_W      = 24,
  parameter logic [ADDR_W-1:0] HANDLER_VEC = 24'hFFFFF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smi_pin_i,
  input  logic              sw_trigger_i,
  input  logic              sw_enable_i,
  input  logic              op_busy_i,
  input  logic              save_done_i,
  input  logic              handler_exit_i,
  input  logic              restore_done_i,
  output logic              pin_oe_o,
  output logic              pin_val_o,
  output logic              mode_active_o,
  output logic              intr_mask_o,
  output logic              pipe_off_o,
  output logic              save_req_o,
  output logic              restore_req_o,
  output logic              handler_go_o,
  output logic [ADDR_W-1:0] fetch_addr_o
);
  logic       rst_n_int;
  logic       pin_low;
  logic       sw_req;
  logic       h_entry;
  smm_state_e state;
  logic       active;

  smm_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  smm_pin_sample u_pin (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .pin_i     (smi_pin_i),
    .pin_low_q (pin_low)
  );

  assign sw_req = sw_trigger_i & sw_enable_i;

  smm_seq_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n_int),
    .hw_req        (pin_low),
    .sw_req        (sw_req),
    .op_busy       (op_busy_i),
    .save_done     (save_done_i),
    .handler_exit  (handler_exit_i),
    .restore_done  (restore_done_i),
    .state         (state),
    .handler_entry (h_entry)
  );

  smm_out_decode #(.ADDR_W(ADDR_W), .HANDLER_VEC(HANDLER_VEC)) u_dec (
    .state         (state),
    .handler_entry (h_entry),
    .pin_oe        (pin_oe_o),
    .pin_val       (pin_val_o),
    .active        (active),
    .save_req      (save_req_o),
    .restore_req   (restore_req_o),
    .handler_go    (handler_go_o),
    .fetch_addr    (fetch_addr_o)
  );

  assign mode_active_o = active;
  assign intr_mask_o   = active;
  assign pipe_off_o    = active;
endmodule

// File: rtl/smm_mode_ctrl_chk.sv
module smm_mode_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic op_busy_i,
  input logic restore_done_i,
  input logic pin_oe_o,
  input logic pin_val_o,
  input logic mode_active_o,
  input logic intr_mask_o,
  input logic pipe_off_o,
  input logic save_req_o,
  input logic restore_req_o,
  input logic handler_go_o
);
  // R3
  save_after_idle_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(save_req_o) |-> $past(!op_busy_i));

  // R3
  drive_only_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe_o |-> mode_active_o);

  // R5
  handler_go_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    handler_go_o |=> !handler_go_o);

  // R6
  preamble_two_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_req_o && restore_done_i) |=> (pin_oe_o && pin_val_o) ##1
      (pin_oe_o && pin_val_o) ##1 !pin_oe_o);

  // R7
  mask_while_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_active_o |-> (intr_mask_o && pipe_off_o));

  // R4
  phases_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(save_req_o && restore_req_o));
endmodule

bind smm_mode_ctrl smm_mode_ctrl_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .op_busy_i      (op_busy_i),
  .restore_done_i (restore_done_i),
  .pin_oe_o       (pin_oe_o),
  .pin_val_o      (pin_val_o),
  .mode_active_o  (mode_active_o),
  .intr_mask_o    (intr_mask_o),
  .pipe_off_o     (pipe_off_o),
  .save_req_o     (save_req_o),
  .restore_req_o  (restore_req_o),
  .handler_go_o   (handler_go_o)
);

// File: tb/tb_smm_mode_ctrl.sv
`timescale 1ns/1ps
module tb_smm_mode_ctrl;
  logic clk = 1'b0;
  logic rst_n;
  logic ext_low, sw_trig, sw_en, busy, sdone, hexit, rdone;
  logic pin_oe, pin_val, active, imask, poff, sreq, rreq, hgo;
  logic [23:0] faddr;
  logic pin_wire;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign pin_wire = pin_oe ? pin_val : ~ext_low;

  smm_mode_ctrl dut (
    .clk(clk), .rst_n(rst_n), .smi_pin_i(pin_wire),
    .sw_trigger_i(sw_trig), .sw_enable_i(sw_en), .op_busy_i(busy),
    .save_done_i(sdone), .handler_exit_i(hexit), .restore_done_i(rdone),
    .pin_oe_o(pin_oe), .pin_val_o(pin_val), .mode_active_o(active),
    .intr_mask_o(imask), .pipe_off_o(poff), .save_req_o(sreq),
    .restore_req_o(rreq), .handler_go_o(hgo), .fetch_addr_o(faddr)
  );

  // inputs {ext_low,sw,en,busy,sdone,hexit,rdone}, expected {active,oe,val,sreq,rreq,hgo}
  localparam logic [12:0] VEC [13] = '{
    {7'b1001000, 6'b000000},
    {7'b1001000, 6'b100000},
    {7'b1001000, 6'b100000},
    {7'b1000000, 6'b110100},
    {7'b0000000, 6'b110100},
    {7'b0000100, 6'b110001},
    {7'b0000000, 6'b110000},
    {7'b0000010, 6'b110010},
    {7'b0000000, 6'b110010},
    {7'b0000001, 6'b111000},
    {7'b0000000, 6'b111000},
    {7'b0000000, 6'b000000},
    {7'b0000000, 6'b000000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_in();
    ext_low = 0; sw_trig = 0; sw_en = 0; busy = 0; sdone = 0; hexit = 0; rdone = 0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic finish_seq();
    sdone = 1; step(); sdone = 0;
    hexit = 1; step(); hexit = 0;
    rdone = 1; step(); rdone = 0;
    step(); step();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    clear_in();
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 active in reset", {31'd0, active}, 0);
    chk("R1 oe in reset", {31'd0, pin_oe}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 outputs after reset", {26'd0, active, pin_oe, sreq, rreq, hgo, imask}, 0);

    // R2 R3 R4 R5 R6 R7: vector walk of a pin request
    for (int i = 0; i < 13; i++) begin
      {ext_low, sw_trig, sw_en, busy, sdone, hexit, rdone} = VEC[i][12:6];
      step();
      chk($sformatf("R2-R6 vec %0d", i),
          {26'd0, active, pin_oe, pin_oe & pin_val, sreq, rreq, hgo},
          {26'd0, VEC[i][5:0]});
      chk($sformatf("R5 fetch vec %0d", i), {8'd0, faddr}, hgo ? 32'hFFFFF0 : 32'd0);
      chk($sformatf("R7 mask vec %0d", i), {30'd0, imask, poff}, {30'd0, active, active});
    end
    clear_in();

    // R8 software request with enable
    sw_trig = 1; sw_en = 1; busy = 1; step(); sw_trig = 0; sw_en = 0;
    chk("R8 sw recognised", {31'd0, active}, 1);
    chk("R8 sw waits for op", {31'd0, pin_oe}, 0);
    step();
    chk("R3 still busy", {31'd0, sreq}, 0);
    busy = 0; step();
    chk("R8 sw drives pin low", {30'd0, pin_oe, pin_wire}, 32'b10);
    sdone = 1; step(); sdone = 0;
    // R9 late requests during handler
    sw_trig = 1; sw_en = 1; ext_low = 1; step(); sw_trig = 0; sw_en = 0; ext_low = 0;
    chk("R9 handler unchanged", {29'd0, sreq, rreq, pin_oe}, 32'b001);
    hexit = 1; step(); hexit = 0;
    rdone = 1; step(); rdone = 0;
    step(); step();
    chk("R9 released", {30'd0, active, pin_oe}, 0);
    step(); step();
    chk("R9 no re-entry", {31'd0, active}, 0);

    // R8 trigger without enable
    sw_trig = 1; sw_en = 0; step(); sw_trig = 0; step();
    chk("R8 disabled trigger ignored", {31'd0, active}, 0);

    // R10 glitch inside one clock period
    #1 ext_low = 1; #2 ext_low = 0;
    @(negedge clk); step();
    chk("R10 glitch ignored", {31'd0, active}, 0);

    // R2 second pin request with op idle, then full release
    ext_low = 1; step(); step();
    chk("R2 pin recognised", {31'd0, active}, 1);
    step(); ext_low = 0;
    chk("R3 save with op idle", {30'd0, sreq, pin_oe}, 32'b11);
    finish_seq();
    chk("R6 released after preamble", {30'd0, pin_oe, active}, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule